// File: doc/BRIEF.md
# Low-Voltage Detect Control and Status Register

This block is the byte-wide software register of a supply monitor. Software sets enables and acknowledges detections through it. An analog comparator drives a single-bit low-voltage indication. That input is resynchronised, qualified by a master enable and by the stop-mode state, and then latched into a sticky detect flag. The flag drives an interrupt request, a system reset request or both, and software reads it back. A separate read/write bit drives the enable of the reference-voltage buffer.

Three configuration bits can be changed only once per reset: reset enable, stop-mode enable and master enable. The first register write after reset freezes them, whatever value that write carries. An acknowledge bit that is only ever written clears the flag. If a detection arrives in the same cycle as an acknowledge, the detection wins.

Top module: `lowv_csr`

## Requirements
- R1: After reset the register reads 0x1C, which means reset enable (bit 4), stop-mode enable (bit 3) and master enable (bit 2) are 1 and every other bit is 0. Both requests and the buffer enable are low.
- R2: Every write loads the interrupt enable (bit 5) and the buffer enable (bit 0) from the write data.
- R3: Only the first write after reset loads bits 4, 3 and 2. Every later write leaves them unchanged until the next reset, and any write at all counts as the first.
- R4: Bit 6 and bit 1 always read as 0, whatever value was written to them.
- R5: A write with bit 6 set clears the detect flag (bit 7). A write with bit 6 clear leaves the flag as it is.
- R6: The comparator input passes through two synchronising flops. The flag therefore reads 1 at the third rising edge after the input rises, and it stays 1 after the input falls.
- R7: While the master enable is 0, the comparator input cannot set the flag.
- R8: While the stop indication is high, the comparator input can set the flag only if the stop-mode enable is 1.
- R9: If a qualified detection and an acknowledge write fall in the same cycle, the flag ends up set.
- R10: The interrupt request is high exactly when the flag and the interrupt enable are both 1.
- R11: The reset request is high exactly when the flag, the reset enable and the master enable are all 1.
- R12: The buffer enable output always equals bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register contents |
| lowVoltIn | input | 1 | Comparator low-voltage indication, asynchronous |
| stopMode | input | 1 | High while the system is in stop mode |
| irqReq | output | 1 | Interrupt request |
| rstReq | output | 1 | System reset request |
| bufEnable | output | 1 | Reference buffer enable |

## Verification
The assertions assume that the write strobe and the stop indication are synchronous to the clock. The comparator input may change at any time, because it is synchronised inside the block. They also assume that a write is a single-cycle strobe with fully defined data. The bench drives every input on the falling edge, so each value is stable and defined at the rising edge. Random write data always has bit 1 cleared, as software must do. A separate directed check writes that bit as 1 to show that it still reads 0.

// File: rtl/lowv_pkg.sv
package lowv_pkg;
  localparam int DATA_W     = 8;
  localparam int FLAG_BIT   = 7;
  localparam int ACK_BIT    = 6;
  localparam int IEN_BIT    = 5;
  localparam int RSTEN_BIT  = 4;
  localparam int STOPEN_BIT = 3;
  localparam int MEN_BIT    = 2;
  localparam int RSVD_BIT   = 1;
  localparam int BUF_BIT    = 0;

  typedef struct packed {
    logic wrOpen;   // load the freely writable bits
    logic wrProt;   // load the once-only bits
    logic clrFlag;  // acknowledge
    logic setFlag;  // qualified detection
  } lowvStrobe_t;
endpackage

// File: rtl/lowv_ctrl.sv
module lowv_ctrl
  import lowv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lowVoltIn,
  input  logic              stopMode,
  input  logic              masterEn,
  input  logic              stopEn,
  output lowvStrobe_t       strobe
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   locked;
  logic                   lvSync;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= lowVoltIn;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lowVoltIn};
    end
  endgenerate

  assign lvSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)     locked <= 1'b0;
    else if (wrEn) locked <= 1'b1;

  always_comb begin
    strobe.wrOpen  = wrEn;
    strobe.wrProt  = wrEn & ~locked;
    strobe.clrFlag = wrEn & wrData[ACK_BIT];
    strobe.setFlag = lvSync & masterEn & (~stopMode | stopEn);
  end
endmodule

// File: rtl/lowv_datapath.sv
module lowv_datapath
  import lowv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  lowvStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              masterEn,
  output logic              stopEn,
  output logic              irqReq,
  output logic              rstReq,
  output logic              bufEnable
);
  logic flagQ, intEnQ, rstEnQ, stopEnQ, masterEnQ, bufEnQ;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      intEnQ <= 1'b0;
      bufEnQ <= 1'b0;
    end else if (strobe.wrOpen) begin
      intEnQ <= wrData[IEN_BIT];
      bufEnQ <= wrData[BUF_BIT];
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rstEnQ    <= 1'b1;
      stopEnQ   <= 1'b1;
      masterEnQ <= 1'b1;
    end else if (strobe.wrProt) begin
      rstEnQ    <= wrData[RSTEN_BIT];
      stopEnQ   <= wrData[STOPEN_BIT];
      masterEnQ <= wrData[MEN_BIT];
    end

  // set wins over acknowledge so no event is lost
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                flagQ <= 1'b0;
    else if (strobe.setFlag)  flagQ <= 1'b1;
    else if (strobe.clrFlag)  flagQ <= 1'b0;

  always_comb begin
    rdData            = '0;
    rdData[FLAG_BIT]  = flagQ;
    rdData[IEN_BIT]   = intEnQ;
    rdData[RSTEN_BIT] = rstEnQ;
    rdData[STOPEN_BIT]= stopEnQ;
    rdData[MEN_BIT]   = masterEnQ;
    rdData[BUF_BIT]   = bufEnQ;
  end

  assign masterEn  = masterEnQ;
  assign stopEn    = stopEnQ;
  assign irqReq    = flagQ & intEnQ;
  assign rstReq    = flagQ & rstEnQ & masterEnQ;
  assign bufEnable = bufEnQ;
endmodule

// File: rtl/lowv_csr.sv
module lowv_csr
  import lowv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              lowVoltIn,
  input  logic              stopMode,
  output logic              irqReq,
  output logic              rstReq,
  output logic              bufEnable
);
  lowvStrobe_t strobe;
  logic        masterEn, stopEn;

  lowv_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .lowVoltIn(lowVoltIn), .stopMode(stopMode),
    .masterEn(masterEn), .stopEn(stopEn), .strobe(strobe)
  );

  lowv_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .rdData(rdData), .masterEn(masterEn), .stopEn(stopEn),
    .irqReq(irqReq), .rstReq(rstReq), .bufEnable(bufEnable)
  );
endmodule

// File: rtl/lowv_csr_chk.sv
module lowv_csr_chk
  import lowv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              stopMode,
  input logic              irqReq,
  input logic              rstReq,
  input logic              bufEnable
);
  logic seenWr;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)     seenWr <= 1'b0;
    else if (wrEn) seenWr <= 1'b1;

  assert_prot_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seenWr && wrEn) |=> (rdData[4:2] == $past(rdData[4:2])));

  assert_zero_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[ACK_BIT] == 1'b0) && (rdData[RSVD_BIT] == 1'b0));

  assert_flag_needs_men_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[FLAG_BIT]) |-> $past(rdData[MEN_BIT]));

  assert_stop_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[FLAG_BIT]) |-> (!$past(stopMode) || $past(rdData[STOPEN_BIT])));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (rdData[FLAG_BIT] & rdData[IEN_BIT]));

  assert_rst_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    rstReq == (rdData[FLAG_BIT] & rdData[RSTEN_BIT] & rdData[MEN_BIT]));

  assert_buf_R12: assert property (@(posedge clk) disable iff (!rstN)
    bufEnable == rdData[BUF_BIT]);
endmodule

bind lowv_csr lowv_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .stopMode(stopMode), .irqReq(irqReq), .rstReq(rstReq), .bufEnable(bufEnable)
);

// File: tb/lowv_csr_tb.sv
module lowv_csr_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       lowVoltIn = 1'b0;
  logic       stopMode = 1'b0;
  logic       irqReq, rstReq, bufEnable;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lowv_csr u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lowVoltIn(lowVoltIn), .stopMode(stopMode),
    .irqReq(irqReq), .rstReq(rstReq), .bufEnable(bufEnable)
  );

  // expected-value model built from the requirements
  logic m1, m2, mFlag, mIen, mRsten, mStopen, mMen, mBuf, mLock;
  logic mEvt;
  assign mEvt = m2 & mMen & (~stopMode | mStopen);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 0; m2 <= 0; mFlag <= 0; mIen <= 0; mBuf <= 0;
      mRsten <= 1; mStopen <= 1; mMen <= 1; mLock <= 0;
    end else begin
      m1 <= lowVoltIn;
      m2 <= m1;
      if (wrEn) begin
        mIen <= wrData[5];
        mBuf <= wrData[0];
        if (!mLock) begin
          mRsten <= wrData[4]; mStopen <= wrData[3]; mMen <= wrData[2];
        end
        mLock <= 1;
      end
      if (mEvt) mFlag <= 1;
      else if (wrEn && wrData[6]) mFlag <= 0;
    end
  end

  function automatic logic [7:0] expReg();
    return {mFlag, 1'b0, mIen, mRsten, mStopen, mMen, 1'b0, mBuf};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0; lowVoltIn = 1'b0; stopMode = 1'b0; wrEn = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    doReset();
    check("R1 reg", rdData, 8'h1C);
    check("R1 outs", {5'd0, irqReq, rstReq, bufEnable}, 8'h00);

    lowVoltIn = 1'b1;
    cyc(2);
    check("R6 not yet", {7'd0, rdData[7]}, 8'h00);
    cyc(1);
    check("R6 set", {7'd0, rdData[7]}, 8'h01);
    check("R11 rst", {7'd0, rstReq}, 8'h01);
    check("R10 no irq", {7'd0, irqReq}, 8'h00);

    doWrite(8'h7C);  // ack while detection persists, ien=1
    check("R9 set wins", rdData, 8'hBC);
    check("R10 irq", {7'd0, irqReq}, 8'h01);

    lowVoltIn = 1'b0;
    cyc(3);
    check("R6 sticky", {7'd0, rdData[7]}, 8'h01);
    doWrite(8'h20);
    check("R5 no ack", rdData, 8'hBC);
    doWrite(8'h40);  // ack, also tries to clear protected bits
    check("R5 R3 ack locked", rdData, 8'h1C);
    doWrite(8'hFF);
    check("R4 R2", rdData, 8'h3D);
    check("R12 buf", {7'd0, bufEnable}, 8'h01);

    doReset();
    doWrite(8'h00);
    check("R3 first write", rdData, 8'h00);
    doWrite(8'h1C);
    check("R3 later write", rdData, 8'h00);
    lowVoltIn = 1'b1;
    cyc(5);
    check("R7 men off", {7'd0, rdData[7]}, 8'h00);

    doReset();
    doWrite(8'h04);
    stopMode = 1'b1; lowVoltIn = 1'b1;
    cyc(5);
    check("R8 stop blocks", {7'd0, rdData[7]}, 8'h00);
    stopMode = 1'b0;
    cyc(1);
    check("R8 run sets", {7'd0, rdData[7]}, 8'h01);
    check("R11 rsten off", {7'd0, rstReq}, 8'h00);

    doReset();
    stopMode = 1'b1; lowVoltIn = 1'b1;
    cyc(3);
    check("R8 stop enabled", {7'd0, rdData[7]}, 8'h01);

    for (int p = 0; p < 6; p++) begin
      doReset();
      for (int c = 0; c < 300; c++) begin
        check("R2 model", rdData, expReg());
        check("R10 model", {7'd0, irqReq}, {7'd0, mFlag & mIen});
        check("R11 model", {7'd0, rstReq}, {7'd0, mFlag & mRsten & mMen});
        check("R12 model", {7'd0, bufEnable}, {7'd0, mBuf});
        wrEn      = ($urandom % 6) == 0;
        wrData    = 8'($urandom) & 8'hFD;
        lowVoltIn = ($urandom % 4) == 0 ? ~lowVoltIn : lowVoltIn;
        stopMode  = ($urandom % 8) == 0 ? ~stopMode : stopMode;
        @(negedge clk);
      end
      wrEn = 1'b0;
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule